// File: doc/BRIEF.md
# Successive-approximation ADC conversion controller

This block is the digital sequencer that sits beside a 10-bit successive-approximation analog core. Software-facing control bits come in as plain inputs: module enable, a start request, stop-in-idle, a clock-source select (system clock or private RC clock) and an interrupt enable. The device power manager supplies sleep, idle and active-low reset. The controller powers the analog core, issues a one-cycle start pulse to it, and takes back a completion strobe with the 10-bit code. When a conversion finishes, the controller sets a done flag, raises an interrupt/wake pulse if enabled, and offers the code on a valid/ready result stream toward the buffer memory. It also holds the last code and presents it as a 16-bit read value in one of four formats.

After the enable goes from 0 to 1, the core gets a programmable settling window, during which the controller reports busy and ignores starts. With the system clock selected, sleep, or idle while stop-in-idle is set, halts the module: any conversion in progress is discarded and is never resumed. With the RC clock selected, a conversion may run through sleep. The start is then held back by a programmable number of cycles, so that the sleep entry can settle first. If such a conversion finishes in sleep with the interrupt disabled, the core is switched off even though the enable input is still 1. It stays off until the enable is taken low.

The result stream follows valid/ready rules. `buf_valid` rises in the cycle after completion and stays high with `buf_data` unchanged until a cycle in which `buf_ready` is high. If a newer completion arrives while a word is still waiting, the newer code replaces the waiting word and only the newest is delivered.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low or `en` is 0, `core_en` is 0 and no `core_go` pulse is issued. After reset, `done_flag`, `busy`, `buf_valid` and `wake_req` are 0.
- R2: After a clock edge that sees `en` at 1 while the module is off, `busy` is 1 for exactly WARM_CYCLES cycles. A start request during that window has no effect.
- R3: With the system clock selected (`clk_sel_rc`=0), a start request sampled while the module is ready produces `core_go` for one cycle, in the cycle directly after that edge. `done_flag` reads 0 in that same cycle.
- R4: With the RC clock selected (`clk_sel_rc`=1), `core_go` appears DEFER_CYCLES cycles later than it would with the system clock. This also holds during sleep.
- R5: A `core_done` strobe during a conversion sets `done_flag`, stores `core_code` as the held result, and raises `buf_valid` with that code, all in the next cycle. Every completion reaches the stream exactly once when `buf_ready` is held high.
- R6: While `buf_valid` is 1 and `buf_ready` is 0, `buf_valid` stays 1 and `buf_data` holds its value. A newer completion replaces the pending word.
- R7: With the system clock selected, sleep discards the running conversion: a `core_done` in the same cycle or later is ignored. The same holds for idle with `stop_in_idle`=1. Starts are ignored while halted, and entering or leaving the halt leaves `done_flag` and `rd_view` unchanged.
- R8: With `stop_in_idle`=0, idle has no effect and a conversion completes normally.
- R9: A completion with `irq_en`=1 gives a one-cycle `wake_req`, whether or not the device is asleep. A completion during sleep with `irq_en`=0 drops `core_en` while `en` is still 1. Starts are then ignored until `en` has been taken low and raised again.
- R10: A start request while a conversion is pending or running produces no further `core_go`.
- R11: `rd_view` depends on `fmt` as follows. 2'b00 gives the code zero-extended. 2'b01 gives the code with bit 9 copied into bits 15:10. 2'b10 and 2'b11 both give the code in bits 15:6 with bits 5:0 zero.
- R12: Reset aborts a conversion in progress and leaves the held result, and so `rd_view`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device reset, active low |
| en | input | 1 | Module enable |
| start_req | input | 1 | Conversion start request |
| stop_in_idle | input | 1 | 1: halt while the device is idle |
| clk_sel_rc | input | 1 | 1: private RC clock, 0: system clock |
| irq_en | input | 1 | Completion interrupt / wake enable |
| sleep | input | 1 | Device is in sleep |
| idle | input | 1 | Device is in idle |
| fmt | input | 2 | Read format select |
| core_done | input | 1 | Analog core completion strobe |
| core_code | input | 10 | Analog core conversion code |
| core_en | output | 1 | Analog core power enable |
| core_go | output | 1 | One-cycle start pulse to the analog core |
| busy | output | 1 | Settling window after enable |
| converting | output | 1 | Conversion pending or running |
| done_flag | output | 1 | Last conversion finished |
| wake_req | output | 1 | Interrupt / wake pulse |
| buf_valid | output | 1 | Result word offered to the buffer |
| buf_ready | input | 1 | Buffer accepts the word |
| buf_data | output | 10 | Right-justified result word |
| rd_view | output | 16 | Held result in the selected format |

## Verification
Two pairs of events can land in the same cycle. The first is a completion strobe from the core in the same cycle that the sleep indication rises with the system clock selected. The bench drives both at the same falling edge; the abort must win, so the done flag stays 0, no result is offered and the held result keeps its value. The second is a new completion while an earlier word is still waiting on a deasserted ready. The scoreboard queue replaces its waiting expectation and checks that only the newer code is delivered, exactly once, when ready returns.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WARM  = 3'd1,
    ST_READY = 3'd2,
    ST_DEFER = 3'd3,
    ST_CONV  = 3'd4,
    ST_SHUT  = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    FMT_UINT  = 2'b00,
    FMT_SINT  = 2'b01,
    FMT_FRAC  = 2'b10,
    FMT_SFRAC = 2'b11
  } view_fmt_t;

endpackage

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic freeze,
  output logic expired
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  assign expired = run && !freeze && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!freeze && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start_req,
  input  logic       rc_sel,
  input  logic       irq_en,
  input  logic       sleep,
  input  logic       halt,
  input  logic       warm_exp,
  input  logic       defer_exp,
  input  logic       core_done,
  output seq_state_t state,
  output logic       complete,
  output logic       core_go,
  output logic       done_flag,
  output logic       wake_req
);
  seq_state_t nxt;
  logic       go_nxt;

  assign complete = en && (state == ST_CONV) && !halt && core_done;

  assign go_nxt = en && !halt &&
                  (((state == ST_READY) && start_req && !rc_sel) ||
                   ((state == ST_DEFER) && defer_exp));

  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:   nxt = ST_WARM;
        ST_WARM:  if (warm_exp) nxt = ST_READY;
        ST_READY: if (start_req && !halt) nxt = rc_sel ? ST_DEFER : ST_CONV;
        ST_DEFER: begin
          if (halt)           nxt = ST_READY;
          else if (defer_exp) nxt = ST_CONV;
        end
        ST_CONV: begin
          if (halt)           nxt = ST_READY;
          else if (core_done) nxt = (sleep && !irq_en) ? ST_SHUT : ST_READY;
        end
        ST_SHUT:  nxt = ST_SHUT;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      core_go   <= 1'b0;
      done_flag <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      state    <= nxt;
      core_go  <= go_nxt;
      wake_req <= complete && irq_en;
      if (go_nxt)        done_flag <= 1'b0;
      else if (complete) done_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_ctrl_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        fmt,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_data,
  output logic [OUT_W-1:0]  rd_view
);
  localparam int PAD = OUT_W - CODE_W;

  logic [CODE_W-1:0] held;

  always_ff @(posedge clk) begin
    if (cap) held <= code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (cap)       out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  assign out_data = held;

  always_comb begin
    case (view_fmt_t'(fmt))
      FMT_UINT:  rd_view = {{PAD{1'b0}}, held};
      FMT_SINT:  rd_view = {{PAD{held[CODE_W-1]}}, held};
      FMT_FRAC,
      FMT_SFRAC: rd_view = {held, {PAD{1'b0}}};
      default:   rd_view = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int WARM_CYCLES  = 8,
  parameter int DEFER_CYCLES = 3,
  parameter int CODE_W       = 10,
  parameter int OUT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_req,
  input  logic              stop_in_idle,
  input  logic              clk_sel_rc,
  input  logic              irq_en,
  input  logic              sleep,
  input  logic              idle,
  input  logic [1:0]        fmt,
  input  logic              core_done,
  input  logic [CODE_W-1:0] core_code,
  output logic              core_en,
  output logic              core_go,
  output logic              busy,
  output logic              converting,
  output logic              done_flag,
  output logic              wake_req,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [CODE_W-1:0] buf_data,
  output logic [OUT_W-1:0]  rd_view
);
  seq_state_t state;
  logic       halt;
  logic       warm_exp;
  logic       defer_exp;
  logic       complete;

  // Clocks stop in sleep unless the private RC source runs the core;
  // idle stops the module only when asked to.
  assign halt = (sleep && !clk_sel_rc) || (idle && stop_in_idle);

  adc_cycle_timer #(.LEN(WARM_CYCLES)) u_warm (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_WARM),
    .freeze  (halt),
    .expired (warm_exp)
  );

  adc_cycle_timer #(.LEN(DEFER_CYCLES)) u_defer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_DEFER),
    .freeze  (halt),
    .expired (defer_exp)
  );

  adc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_req (start_req),
    .rc_sel    (clk_sel_rc),
    .irq_en    (irq_en),
    .sleep     (sleep),
    .halt      (halt),
    .warm_exp  (warm_exp),
    .defer_exp (defer_exp),
    .core_done (core_done),
    .state     (state),
    .complete  (complete),
    .core_go   (core_go),
    .done_flag (done_flag),
    .wake_req  (wake_req)
  );

  adc_result_port #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (complete),
    .code      (core_code),
    .fmt       (fmt),
    .out_ready (buf_ready),
    .out_valid (buf_valid),
    .out_data  (buf_data),
    .rd_view   (rd_view)
  );

  assign core_en    = (state != ST_OFF) && (state != ST_SHUT);
  assign busy       = (state == ST_WARM);
  assign converting = (state == ST_DEFER) || (state == ST_CONV);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              sleep,
  input logic              clk_sel_rc,
  input logic              core_done,
  input logic              core_en,
  input logic              core_go,
  input logic              busy,
  input logic              done_flag,
  input logic              wake_req,
  input logic              buf_valid,
  input logic              buf_ready,
  input logic [CODE_W-1:0] buf_data
);
  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!core_en && !core_go));

  assert_no_go_while_settling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !core_go);

  assert_go_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |-> core_en);

  assert_hold_pending_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready && !core_done) |=> (buf_valid && $stable(buf_data)));

  assert_no_go_in_sysclk_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !clk_sel_rc) |=> !core_go);

  assert_wake_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> done_flag);

  assert_single_go_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_go |=> !core_go);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .sleep      (sleep),
  .clk_sel_rc (clk_sel_rc),
  .core_done  (core_done),
  .core_en    (core_en),
  .core_go    (core_go),
  .busy       (busy),
  .done_flag  (done_flag),
  .wake_req   (wake_req),
  .buf_valid  (buf_valid),
  .buf_ready  (buf_ready),
  .buf_data   (buf_data)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int W = 8;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n, en, start_req, stop_in_idle, clk_sel_rc, irq_en, sleep, idle;
  logic [1:0] fmt;
  logic core_done;
  logic [9:0] core_code;
  logic core_en, core_go, busy, converting, done_flag, wake_req, buf_valid, buf_ready;
  logic [9:0] buf_data;
  logic [15:0] rd_view;

  adc_seq_ctrl #(.WARM_CYCLES(W), .DEFER_CYCLES(D)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .start_req(start_req),
    .stop_in_idle(stop_in_idle), .clk_sel_rc(clk_sel_rc), .irq_en(irq_en),
    .sleep(sleep), .idle(idle), .fmt(fmt), .core_done(core_done),
    .core_code(core_code), .core_en(core_en), .core_go(core_go), .busy(busy),
    .converting(converting), .done_flag(done_flag), .wake_req(wake_req),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_data(buf_data),
    .rd_view(rd_view)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;
  logic [9:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every accepted word (R5, R6).
  always begin
    @(negedge clk);
    #2;
    if (rst_n === 1'b1 && buf_valid === 1'b1 && buf_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected stream word", {22'd0, buf_data}, 32'hFFFF_FFFF);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R5 scoreboard word", {22'd0, buf_data}, {22'd0, e});
      end
    end
  end

  task automatic start_pulse();
    start_req = 1'b1;
    step();
    start_req = 1'b0;
  endtask

  task automatic wait_go(output int n);
    n = 1;
    while (core_go !== 1'b1 && n < 20) begin
      step();
      n++;
    end
  endtask

  // Driver: completes a conversion and pushes the expected word.
  task automatic finish(input logic [9:0] code, input bit expect_word);
    if (expect_word) begin
      if (buf_valid === 1'b1 && buf_ready === 1'b0 && exp_q.size() > 0)
        void'(exp_q.pop_back());
      exp_q.push_back(code);
    end
    core_code = code;
    core_done = 1'b1;
    step();
    core_done = 1'b0;
  endtask

  task automatic convert(input logic [9:0] code, input string tag);
    int n;
    start_pulse();
    wait_go(n);
    chk({tag, " go latency"}, n, clk_sel_rc ? D + 1 : 1);
    step();
    step();
    finish(code, 1'b1);
    chk({tag, " done set"}, done_flag, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] v0;
    rst_n = 0; en = 0; start_req = 0; stop_in_idle = 0; clk_sel_rc = 0;
    irq_en = 0; sleep = 0; idle = 0; fmt = 2'b00; core_done = 0;
    core_code = '0; buf_ready = 1;
    repeat (3) step();
    // R1 reset state
    chk("R1 reset core_en", core_en, 0);
    chk("R1 reset done", done_flag, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset valid", buf_valid, 0);
    chk("R1 reset wake", wake_req, 0);
    rst_n = 1;
    step();
    // R1 disabled: start has no effect
    start_req = 1;
    step(); step();
    chk("R1 disabled go", core_go, 0);
    chk("R1 disabled core_en", core_en, 0);
    start_req = 0;

    // R2 settling window, starts ignored
    en = 1;
    step();
    start_req = 1;
    for (int i = 1; i <= W; i++) begin
      chk("R2 busy in window", busy, 1);
      chk("R2 no go in window", core_go, 0);
      step();
    end
    start_req = 0;
    chk("R2 busy released", busy, 0);
    chk("R2 no go after window", core_go, 0);
    chk("R2 core powered", core_en, 1);

    // R3 system clock start, R5 completion, R11 unsigned view
    convert(10'h2A5, "R3");
    #1;
    chk("R11 uint view", rd_view, 16'h02A5);
    chk("R11 sint view neg", 32'(u0.rd_view), 32'(rd_view));
    fmt = 2'b01; #1;
    chk("R11 sint view", rd_view, {{6{1'b1}}, 10'h2A5});

    // R3 done cleared at go, R10 start during conversion ignored
    fmt = 2'b00;
    start_pulse();
    wait_go(n);
    chk("R3 go latency second", n, 1);
    chk("R3 done cleared at go", done_flag, 0);
    chk("R3 converting", converting, 1);
    start_req = 1;
    step();
    start_req = 0;
    chk("R10 no extra go a", core_go, 0);
    step();
    chk("R10 no extra go b", core_go, 0);
    finish(10'h3C1, 1'b1);
    chk("R5 done after second", done_flag, 1);
    fmt = 2'b00; #1; chk("R11 fmt00", rd_view, {6'b0, 10'h3C1});
    fmt = 2'b01; #1; chk("R11 fmt01", rd_view, {{6{1'b1}}, 10'h3C1});
    fmt = 2'b10; #1; chk("R11 fmt10", rd_view, {10'h3C1, 6'b0});
    fmt = 2'b11; #1; chk("R11 fmt11", rd_view, {10'h3C1, 6'b0});
    fmt = 2'b00;

    // R6 back-pressure and overwrite
    buf_ready = 0;
    convert(10'h155, "R6a");
    fmt = 2'b01; #1;
    chk("R11 sint positive", rd_view, 16'h0155);
    fmt = 2'b00;
    chk("R6 valid raised", buf_valid, 1);
    repeat (3) step();
    chk("R6 valid held", buf_valid, 1);
    chk("R6 data held", buf_data, 10'h155);
    convert(10'h0F0, "R6b");
    chk("R6 overwrite data", buf_data, 10'h0F0);
    chk("R6 still valid", buf_valid, 1);
    buf_ready = 1;
    step(); step();
    chk("R6 drained", buf_valid, 0);
    chk("R6 queue empty", exp_q.size(), 0);

    // R7 sleep with done set leaves registers unchanged
    v0 = rd_view;
    sleep = 1;
    step(); step();
    sleep = 0;
    step();
    #1;
    chk("R7 done kept over sleep", done_flag, 1);
    chk("R7 view kept over sleep", rd_view, v0);

    // R7 abort: sleep and completion in the same cycle
    start_pulse();
    wait_go(n);
    step();
    sleep = 1;
    core_code = 10'h3FF;
    core_done = 1;
    step();
    core_done = 0;
    chk("R7 same-cycle abort done", done_flag, 0);
    chk("R7 same-cycle abort valid", buf_valid, 0);
    #1;
    chk("R7 abort view", rd_view, v0);
    start_pulse();
    repeat (4) begin
      chk("R7 start ignored asleep", core_go, 0);
      step();
    end
    sleep = 0;
    step();
    core_done = 1;
    step();
    core_done = 0;
    chk("R7 no resume", done_flag, 0);
    chk("R7 no resume valid", buf_valid, 0);

    // R7 idle with stop_in_idle
    stop_in_idle = 1;
    start_pulse();
    wait_go(n);
    idle = 1;
    step();
    core_done = 1;
    step();
    core_done = 0;
    chk("R7 idle abort", done_flag, 0);
    idle = 0;
    step();

    // R8 idle without stop_in_idle keeps running
    stop_in_idle = 0;
    idle = 1;
    convert(10'h123, "R8");
    idle = 0;

    // R4 RC start during sleep, R9 wake
    clk_sel_rc = 1;
    sleep = 1;
    irq_en = 1;
    convert(10'h2C4, "R4");
    chk("R9 wake pulse in sleep", wake_req, 1);
    chk("R9 core powered", core_en, 1);
    step();
    chk("R9 wake one cycle", wake_req, 0);

    // R9 completion in sleep with interrupt off shuts the core
    irq_en = 0;
    convert(10'h0AB, "R9");
    chk("R9 no wake", wake_req, 0);
    chk("R9 core shut", core_en, 0);
    chk("R9 enable still set", en, 1);
    start_pulse();
    repeat (5) begin
      chk("R9 start ignored shut", core_go, 0);
      step();
    end
    sleep = 0;
    clk_sel_rc = 0;
    start_pulse();
    step();
    chk("R9 still shut awake", core_en, 0);
    en = 0;
    step();
    en = 1;
    step();
    chk("R9 re-enable settles", busy, 1);
    n = 0;
    while (busy === 1'b1 && n < 40) begin step(); n++; end

    // R9 interrupt while awake
    irq_en = 1;
    convert(10'h200, "R9c");
    chk("R9 wake awake", wake_req, 1);
    irq_en = 0;
    step();

    // R12 reset mid-conversion keeps the held result
    fmt = 2'b00;
    #1;
    v0 = rd_view;
    chk("R12 pre-reset view", v0, 16'h0200);
    start_pulse();
    wait_go(n);
    rst_n = 0;
    step();
    #1;
    chk("R12 reset core_en", core_en, 0);
    chk("R12 reset done", done_flag, 0);
    chk("R12 reset valid", buf_valid, 0);
    chk("R12 view kept", rd_view, v0);
    rst_n = 1;
    step(); step();
    chk("R5 all words delivered", exp_q.size(), 0);

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule